// File: doc/BRIEF.md
# UART Host Register Bank with Divisor Banking

This block is the processor-side register file of a classic asynchronous serial controller. A host reaches it through a 3-bit register index, a chip select, a read strobe, a write strobe and an 8-bit write bus. Read data comes back combinationally on an 8-bit read bus.

The block stores the writable registers: transmit holding, interrupt enable, line control, modem control and the two divisor bytes. It exposes their values to the serial datapath. Status values come in as inputs from logic outside this block: receive data, interrupt identification, line status and modem status.

Bit 7 of the line control register is a bank-select bit. It moves indexes 0 and 1 from the data and interrupt-enable registers onto the divisor bytes. The block also produces single-cycle strobes that tell the receiver that its buffer was read and tell the transmitter that a new byte was loaded.

A synchronous active-high master reset clears the control registers. It leaves the transmit holding register and both divisor bytes unchanged.

Top module: `uart_host_regs`

## Requirements
- R1: With line-control bit 7 clear, a read at index 0 returns `rx_byte`, and a write at index 0 stores the write byte into `thr_q`.
- R2: With line-control bit 7 clear, index 1 is the interrupt-enable register. A write takes effect on the capturing edge, and a read returns the stored value.
- R3: With line-control bit 7 set, index 0 reads and writes the divisor low byte and index 1 reads and writes the divisor high byte. `divisor` equals {high, low} right after the capturing edge, and `thr_q` and `ier_q` are left unchanged.
- R4: Indexes 2 to 6 ignore line-control bit 7. Index 2 reads `iid_in`, index 3 is line control (read/write), index 4 is modem control (read/write), index 5 reads `lsr_in` and index 6 reads `msr_in`.
- R5: Writes at indexes 2, 5, 6 and 7 change no stored register.
- R6: A read at index 7 returns 0x00, and `rdata` is 0x00 whenever no read access (`cs` and `rd` both high) is in progress.
- R7: `rx_read_stb` is high for exactly one cycle, the cycle after the first edge of a read access at index 0 with bit 7 clear, however long the access lasts. It stays low when bit 7 is set.
- R8: `tx_load_stb` is high for exactly one cycle, the cycle after the first edge of a write access at index 0 with bit 7 clear. It stays low when bit 7 is set.
- R9: While `mreset` is high at an edge, interrupt enable, line control, modem control and both strobes clear to 0. `thr_q` and `divisor` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mreset | input | 1 | Synchronous active-high master reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| rx_byte | input | 8 | Receive buffer content from the receiver |
| iid_in | input | 8 | Interrupt identification value |
| lsr_in | input | 8 | Line status value |
| msr_in | input | 8 | Modem status value |
| thr_q | output | 8 | Transmit holding register |
| ier_q | output | 8 | Interrupt enable register |
| lcr_q | output | 8 | Line control register |
| mcr_q | output | 8 | Modem control register |
| divisor | output | 16 | Baud divisor {high byte, low byte} |
| rx_read_stb | output | 1 | One-cycle receive-buffer-read strobe |
| tx_load_stb | output | 1 | One-cycle transmit-load strobe |

## Verification
Read data is combinational, so it is valid in the same cycle the access is driven. Stored registers and the divisor change on the edge that captures the write. Both strobes rise on that same edge and fall on the next one.

The bench drives every access at a falling edge. Each expected item is queued with the cycle it is due in, either one or more edges after the drive. The monitor compares each item 3 ns after the matching rising edge, while the inputs are still held. Strobe checks are queued for the first edge and for every later edge of the access, which confirms that each strobe lasts one cycle.

// File: rtl/uart_host_regs.sv
module uart_host_regs #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          mreset,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] iid_in,
  input  logic [DW-1:0] lsr_in,
  input  logic [DW-1:0] msr_in,
  output logic [DW-1:0] thr_q,
  output logic [DW-1:0] ier_q,
  output logic [DW-1:0] lcr_q,
  output logic [DW-1:0] mcr_q,
  output logic [2*DW-1:0] divisor,
  output logic          rx_read_stb,
  output logic          tx_load_stb
);

  localparam logic [AW-1:0] IX_DATA = AW'(0);
  localparam logic [AW-1:0] IX_IER  = AW'(1);
  localparam logic [AW-1:0] IX_IID  = AW'(2);
  localparam logic [AW-1:0] IX_LCR  = AW'(3);
  localparam logic [AW-1:0] IX_MCR  = AW'(4);
  localparam logic [AW-1:0] IX_LSR  = AW'(5);
  localparam logic [AW-1:0] IX_MSR  = AW'(6);

  logic [DW-1:0] dll_q, dlm_q;
  logic rd_acc, wr_acc, rd_prev, wr_prev, bank;

  assign bank    = lcr_q[DW-1];
  assign rd_acc  = cs && rd;
  assign wr_acc  = cs && wr;
  assign divisor = {dlm_q, dll_q};

  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      case (addr)
        IX_DATA: rdata = bank ? dll_q : rx_byte;
        IX_IER:  rdata = bank ? dlm_q : ier_q;
        IX_IID:  rdata = iid_in;
        IX_LCR:  rdata = lcr_q;
        IX_MCR:  rdata = mcr_q;
        IX_LSR:  rdata = lsr_in;
        IX_MSR:  rdata = msr_in;
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mreset) begin
      ier_q       <= '0;
      lcr_q       <= '0;
      mcr_q       <= '0;
      rd_prev     <= 1'b0;
      wr_prev     <= 1'b0;
      rx_read_stb <= 1'b0;
      tx_load_stb <= 1'b0;
    end else begin
      rd_prev     <= rd_acc;
      wr_prev     <= wr_acc;
      rx_read_stb <= rd_acc && !rd_prev && addr == IX_DATA && !bank;
      tx_load_stb <= wr_acc && !wr_prev && addr == IX_DATA && !bank;
      if (wr_acc) begin
        case (addr)
          IX_IER: if (!bank) ier_q <= wdata;
          IX_LCR: lcr_q <= wdata;
          IX_MCR: mcr_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!mreset && wr_acc) begin
      if (addr == IX_DATA && !bank) thr_q <= wdata;
      if (addr == IX_DATA &&  bank) dll_q <= wdata;
      if (addr == IX_IER  &&  bank) dlm_q <= wdata;
    end
  end

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (mreset)
    $past(mreset) |-> (ier_q == '0 && lcr_q == '0 && mcr_q == '0 && !rx_read_stb && !tx_load_stb));

  a_r5_ro_write_ignored: assert property (@(posedge clk) disable iff (mreset)
    (wr_acc && (addr == IX_IID || addr == IX_LSR || addr == IX_MSR || addr == AW'(7)))
    |=> ($stable(ier_q) && $stable(lcr_q) && $stable(mcr_q)));

  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (mreset)
    (rd_acc && addr == AW'(7)) |-> rdata == '0);

  a_r7_rx_stb_single: assert property (@(posedge clk) disable iff (mreset)
    rx_read_stb |=> !rx_read_stb);

  a_r7_rx_stb_cause: assert property (@(posedge clk) disable iff (mreset)
    rx_read_stb |-> $past(cs && rd && addr == IX_DATA && !lcr_q[DW-1]));

  a_r8_tx_stb_single: assert property (@(posedge clk) disable iff (mreset)
    tx_load_stb |=> !tx_load_stb);

endmodule

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;
  logic clk = 0, mreset = 1, cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, rx_byte = 8'h3C, iid_in = 8'hC2, lsr_in = 8'h60, msr_in = 8'hB0;
  logic [7:0] thr_q, ier_q, lcr_q, mcr_q;
  logic [15:0] divisor;
  logic rx_read_stb, tx_load_stb;

  uart_host_regs i_uart_host_regs (.*);

  always #5 clk = ~clk;

  typedef enum int {K_RD, K_DIV, K_IER, K_LCR, K_MCR, K_THR, K_RXS, K_TXS} kind_t;
  typedef struct { kind_t k; logic [15:0] exp; int due; string req; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] got(kind_t k);
    case (k)
      K_RD:  return {8'h0, rdata};
      K_DIV: return divisor;
      K_IER: return {8'h0, ier_q};
      K_LCR: return {8'h0, lcr_q};
      K_MCR: return {8'h0, mcr_q};
      K_THR: return {8'h0, thr_q};
      K_RXS: return {15'h0, rx_read_stb};
      default: return {15'h0, tx_load_stb};
    endcase
  endfunction

  always @(posedge clk) begin
    #3;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        checks++;
        if (q[i].due < cyc || got(q[i].k) !== q[i].exp) begin
          errors++;
          $display("FAIL %s kind=%s actual=%h expected=%h", q[i].req, q[i].k.name(), got(q[i].k), q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic start(bit r, bit w, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = r; wr = w; addr = a; wdata = d;
  endtask

  task automatic expect_v(kind_t k, logic [15:0] v, int dly, string req);
    q.push_back('{k, v, cyc + dly, req});
  endtask

  task automatic idle();
    @(negedge clk);
    cs = 0; rd = 0; wr = 0;
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    start(0, 1, a, d);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    mreset = 0;
    expect_v(K_IER, 0, 1, "R9"); expect_v(K_LCR, 0, 1, "R9"); expect_v(K_MCR, 0, 1, "R9");
    expect_v(K_RXS, 0, 1, "R9"); expect_v(K_TXS, 0, 1, "R9");

    start(0, 1, 3'd0, 8'hA5);
    expect_v(K_THR, 16'hA5, 1, "R1"); expect_v(K_TXS, 1, 1, "R8"); expect_v(K_TXS, 0, 2, "R8");
    idle();
    start(1, 0, 3'd0, 0);
    expect_v(K_RD, 16'h3C, 1, "R1"); expect_v(K_RXS, 1, 1, "R7"); expect_v(K_RXS, 0, 2, "R7");
    idle();
    start(0, 1, 3'd1, 8'h0F);
    expect_v(K_IER, 16'h0F, 1, "R2");
    idle();
    start(1, 0, 3'd1, 0); expect_v(K_RD, 16'h0F, 1, "R2"); idle();

    start(0, 1, 3'd3, 8'h83); expect_v(K_LCR, 16'h83, 1, "R4"); idle();
    start(0, 1, 3'd0, 8'h34);
    expect_v(K_TXS, 0, 1, "R8"); expect_v(K_THR, 16'hA5, 1, "R3");
    idle();
    start(0, 1, 3'd1, 8'h12);
    expect_v(K_DIV, 16'h1234, 1, "R3"); expect_v(K_IER, 16'h0F, 1, "R3");
    idle();
    start(1, 0, 3'd0, 0); expect_v(K_RD, 16'h34, 1, "R3"); expect_v(K_RXS, 0, 1, "R7"); idle();
    start(1, 0, 3'd1, 0); expect_v(K_RD, 16'h12, 1, "R3"); idle();
    start(1, 0, 3'd2, 0); expect_v(K_RD, 16'hC2, 1, "R4"); idle();
    start(1, 0, 3'd5, 0); expect_v(K_RD, 16'h60, 1, "R4"); idle();
    start(1, 0, 3'd6, 0); expect_v(K_RD, 16'hB0, 1, "R4"); idle();
    start(0, 1, 3'd4, 8'h1F); expect_v(K_MCR, 16'h1F, 1, "R4"); idle();
    start(1, 0, 3'd4, 0); expect_v(K_RD, 16'h1F, 1, "R4"); idle();

    foreach (q[i]) ;
    wr_reg(3'd2, 8'hFF); wr_reg(3'd5, 8'hFF); wr_reg(3'd6, 8'hFF); wr_reg(3'd7, 8'hFF);
    @(negedge clk);
    expect_v(K_IER, 16'h0F, 1, "R5"); expect_v(K_LCR, 16'h83, 1, "R5");
    expect_v(K_MCR, 16'h1F, 1, "R5"); expect_v(K_DIV, 16'h1234, 1, "R5"); expect_v(K_THR, 16'hA5, 1, "R5");

    start(1, 0, 3'd7, 0); expect_v(K_RD, 0, 1, "R6"); idle();
    @(negedge clk); cs = 0; rd = 1; addr = 3'd3; expect_v(K_RD, 0, 1, "R6");
    @(negedge clk); rd = 0;

    start(0, 1, 3'd3, 8'h03); expect_v(K_LCR, 16'h03, 1, "R4"); idle();
    start(1, 0, 3'd0, 0);
    expect_v(K_RXS, 1, 1, "R7"); expect_v(K_RXS, 0, 2, "R7"); expect_v(K_RXS, 0, 3, "R7");
    expect_v(K_RD, 16'h3C, 3, "R1");
    @(negedge clk); @(negedge clk); idle();
    start(0, 1, 3'd0, 8'h5A);
    expect_v(K_TXS, 1, 1, "R8"); expect_v(K_TXS, 0, 2, "R8"); expect_v(K_THR, 16'h5A, 2, "R1");
    @(negedge clk); idle();

    @(negedge clk); mreset = 1;
    @(negedge clk); @(negedge clk); mreset = 0;
    expect_v(K_IER, 0, 1, "R9"); expect_v(K_LCR, 0, 1, "R9"); expect_v(K_MCR, 0, 1, "R9");
    expect_v(K_THR, 16'h5A, 1, "R9"); expect_v(K_DIV, 16'h1234, 1, "R9");
    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL pending items=%0d expected=0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule